// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block takes a vector of level interrupt lines and routes each one to one or more of up to four CPU interfaces. Each source has an enable bit, a priority value and a CPU target set, all loaded through a narrow register write port. A rising edge on a source line marks the source pending for every CPU in its target set. Pending state is held separately for each source and CPU pair.

Each CPU interface looks at the sources that are pending for that CPU, enabled, and targeted at that CPU. It presents the one with the best priority as an ID together with a valid flag. A CPU takes an interrupt by acknowledging the ID it is being shown. A global clearing mode decides what the acknowledge clears. In shared mode it clears the source for every CPU. In private mode it clears it only for the CPU that acknowledged, and the source stays pending for the other CPUs in its target set.

Top module: `irqd_top`

## Requirements
- R1: While reset is asserted and after it is released, all `irq_valid` bits are 0. At reset every source is disabled, has priority 0 and an empty target set, and the clearing mode is shared (0).
- R2: A disabled source is never presented. A rising edge seen while a source is disabled still latches its pending state, and the source is presented once `cfg_field`=0 (enable) is written with `cfg_data[0]`=1.
- R3: Among the eligible sources of a CPU, the one with the numerically lowest priority value (`cfg_field`=1, `cfg_data[3:0]`) is presented.
- R4: When eligible sources have equal priority, the one with the lowest source ID is presented.
- R5: A CPU sees a source only if bit c of its target set is 1 (`cfg_field`=2, `cfg_data[c]` is CPU c). Different CPUs may present different sources in the same cycle.
- R6: In shared mode (`cfg_field`=3, `cfg_data[0]`=0), an accepted acknowledge clears the source's pending state for all CPUs.
- R7: In private mode (`cfg_field`=3, `cfg_data[0]`=1), an accepted acknowledge clears the pending state only for the acknowledging CPU. Other targeted CPUs keep presenting the source.
- R8: A source line rising before clock edge k is presented after edge k+1. A configuration write or an acknowledge taking effect at edge k changes the presented output after edge k+1.
- R9: An acknowledge is accepted only when that CPU's `irq_valid` is 1 and `ack_id` equals its presented `irq_id`. Any other acknowledge leaves all pending state unchanged.
- R10: Only a rising edge of a source line sets pending state. A line held high after its acknowledge does not set it again. A new low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt source levels, bit s is source s |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 enable, 1 priority, 2 target set, 3 clearing mode |
| cfg_src | input | ID_W | Source the write applies to (ignored for field 3) |
| cfg_data | input | CFG_W | Write data |
| ack_valid | input | NUM_CPU | Acknowledge strobe, one bit per CPU |
| ack_id | input | NUM_CPU*ID_W | Acknowledged ID, CPU c at bits [c*ID_W +: ID_W] |
| irq_valid | output | NUM_CPU | CPU c has an interrupt presented |
| irq_id | output | NUM_CPU*ID_W | Presented ID, CPU c at bits [c*ID_W +: ID_W] |

## Verification
The bench targets the cases where the clearing modes differ. It acknowledges a source shared by two CPUs in each mode and then checks the other CPU. A design with the modes swapped either leaves a stale interrupt behind or loses one. Acknowledges with a wrong ID, and acknowledges to a CPU that shows nothing, are checked against the pending state seen by other CPUs. A design that ignored the ID match would silently drop interrupts. Further tests cover held-high lines after an acknowledge (a level-triggered design would re-fire) and equal priorities (a design breaking ties upward would present the higher ID). A priority rewrite is sampled one cycle early and one cycle on time to pin the output latency.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_PRIO   = 2'd1,
    FLD_TARGET = 2'd2,
    FLD_MODE   = 2'd3
  } cfg_field_e;

  // Lower numeric value wins; equal values do not beat an earlier pick.
  function automatic logic prio_beats(input logic [7:0] cand, input logic [7:0] best);
    return cand < best;
  endfunction

  // New pending row: clear first, then a fresh edge sets again.
  function automatic logic [7:0] pend_next(input logic [7:0] cur,
                                           input logic [7:0] set_m,
                                           input logic [7:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 5,
  parameter int CFG_W   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [1:0]                            cfg_field,
  input  logic [ID_W-1:0]                       cfg_src,
  input  logic [CFG_W-1:0]                      cfg_data,
  output logic [NUM_SRC-1:0]                    en_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]        prio_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]       tgt_o,
  output logic                                  mode_o
);
  import irqd_pkg::*;

  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_field);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit;
    assign hit = cfg_we && (cfg_src == ID_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[s]   <= 1'b0;
        prio_o[s] <= '0;
        tgt_o[s]  <= '0;
      end else if (hit) begin
        case (fld)
          FLD_ENABLE: en_o[s]   <= cfg_data[0];
          FLD_PRIO:   prio_o[s] <= cfg_data[PRIO_W-1:0];
          FLD_TARGET: tgt_o[s]  <= cfg_data[NUM_CPU-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mode_o <= 1'b0;
    else if (cfg_we && fld == FLD_MODE)     mode_o <= cfg_data[0];
  end

endmodule

// File: rtl/irqd_pend.sv
module irqd_pend #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                irq_in,
  input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   tgt,
  input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   clr,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   pend,
  output logic [NUM_SRC-1:0]                rise
);
  import irqd_pkg::*;

  logic [NUM_SRC-1:0] irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  assign rise = irq_in & ~irq_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_row
    logic [NUM_CPU-1:0] set_m;
    assign set_m = rise[s] ? tgt[s] : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[s] <= '0;
      else        pend[s] <= NUM_CPU'(pend_next(8'(pend[s]), 8'(set_m), 8'(clr[s])));
    end
  end

endmodule

// File: rtl/irqd_arb.sv
module irqd_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           valid_o,
  output logic [ID_W-1:0]                id_o
);
  import irqd_pkg::*;

  logic              win_v;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_p;

  always_comb begin
    win_v  = 1'b0;
    win_id = '0;
    win_p  = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (elig[s] && (!win_v || prio_beats(8'(prio[s]), 8'(win_p)))) begin
        win_v  = 1'b1;
        win_id = ID_W'(s);
        win_p  = prio[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      id_o    <= '0;
    end else begin
      valid_o <= win_v;
      id_o    <= win_id;
    end
  end

endmodule

// File: rtl/irqd_top.sv
module irqd_top #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CFG_W  = (PRIO_W > NUM_CPU) ? PRIO_W : NUM_CPU
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_in,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_field,
  input  logic [ID_W-1:0]           cfg_src,
  input  logic [CFG_W-1:0]          cfg_data,
  input  logic [NUM_CPU-1:0]        ack_valid,
  input  logic [NUM_CPU*ID_W-1:0]   ack_id,
  output logic [NUM_CPU-1:0]        irq_valid,
  output logic [NUM_CPU*ID_W-1:0]   irq_id
);

  logic [NUM_SRC-1:0]                en_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]   tgt_q;
  logic                              mode_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]   pend;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]   clr;
  logic [NUM_SRC-1:0]                rise;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   elig;
  logic [NUM_CPU-1:0][ID_W-1:0]      aid;
  logic [NUM_CPU-1:0][ID_W-1:0]      pid;
  logic [NUM_CPU-1:0]                ack_ok;

  irqd_cfg #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W),
             .ID_W(ID_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_src(cfg_src), .cfg_data(cfg_data),
    .en_o(en_q), .prio_o(prio_q), .tgt_o(tgt_q), .mode_o(mode_q)
  );

  irqd_pend #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tgt(tgt_q),
    .clr(clr), .pend(pend), .rise(rise)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign aid[c] = ack_id[c*ID_W +: ID_W];
    assign irq_id[c*ID_W +: ID_W] = pid[c];
    assign ack_ok[c] = ack_valid[c] && irq_valid[c] && (aid[c] == pid[c]);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_el
      assign elig[c][s] = pend[s][c] && en_q[s] && tgt_q[s][c];
    end

    irqd_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .elig(elig[c]), .prio(prio_q),
      .valid_o(irq_valid[c]), .id_o(pid[c])
    );
  end

  // Clear matrix from accepted acknowledges, per clearing mode.
  always_comb begin
    clr = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (ack_ok[c]) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (aid[c] == ID_W'(s)) begin
            if (mode_q) clr[s][c] = 1'b1;
            else        clr[s]    = '1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 5
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CPU-1:0]              irq_valid,
  input logic [NUM_CPU*ID_W-1:0]         irq_id,
  input logic [NUM_CPU-1:0]              ack_ok,
  input logic [NUM_CPU*ID_W-1:0]         ack_id,
  input logic [NUM_SRC-1:0]              rise,
  input logic [NUM_SRC-1:0][NUM_CPU-1:0] pend,
  input logic [NUM_SRC-1:0]              en,
  input logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input logic [NUM_SRC-1:0][NUM_CPU-1:0] tgt,
  input logic                            mode
);

  logic [NUM_SRC-1:0]              en_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] tgt_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= '0; prio_d <= '0; tgt_d <= '0; pend_d <= '0;
    end else begin
      en_d <= en; prio_d <= prio; tgt_d <= tgt; pend_d <= pend;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> irq_valid == '0);

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok == '0 && rise == '0) |=> $stable(pend));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    logic [ID_W-1:0] oid, kid;
    logic better, tie_lower;
    assign oid = irq_id[c*ID_W +: ID_W];
    assign kid = ack_id[c*ID_W +: ID_W];

    always_comb begin
      better = 1'b0;
      tie_lower = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (pend_d[s][c] && en_d[s] && tgt_d[s][c]) begin
          if (prio_d[s] < prio_d[oid]) better = 1'b1;
          if (prio_d[s] == prio_d[oid] && ID_W'(s) < oid) tie_lower = 1'b1;
        end
      end
    end

    p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid[c] |-> en_d[oid]);
    p_best_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid[c] |-> !better);
    p_tie_low_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid[c] |-> !tie_lower);
    p_targeted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid[c] |-> (tgt_d[oid][c] && pend_d[oid][c]));
    p_shared_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ok[c] && !mode && !rise[kid]) |=> pend[$past(kid)] == '0);
    p_private_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ok[c] && mode && !rise[kid]) |=> !pend[$past(kid)][c]);
  end

endmodule

bind irqd_top irqd_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W),
                         .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_id(irq_id),
  .ack_ok(ack_ok), .ack_id(ack_id), .rise(rise), .pend(pend),
  .en(en_q), .prio(prio_q), .tgt(tgt_q), .mode(mode_q)
);

// File: tb/irqd_top_tb.sv
module irqd_top_tb;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int IW = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NS-1:0]  irq_in = '0;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_field = '0;
  logic [IW-1:0]  cfg_src = '0;
  logic [3:0]     cfg_data = '0;
  logic [NC-1:0]  ack_valid = '0;
  logic [NC*IW-1:0] ack_id = '0;
  logic [NC-1:0]  irq_valid;
  logic [NC*IW-1:0] irq_id;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irqd_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_field(cfg_field), .cfg_src(cfg_src), .cfg_data(cfg_data),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .irq_valid(irq_valid), .irq_id(irq_id)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] f, input int src, input logic [3:0] d);
    cfg_we = 1'b1; cfg_field = f; cfg_src = IW'(src); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup_src(input int src, input logic [3:0] p, input logic [3:0] t,
                           input logic e);
    wr(2'd1, src, p);
    wr(2'd2, src, t);
    wr(2'd0, src, {3'b0, e});
  endtask

  task automatic ack(input int cpu, input int id);
    ack_valid = '0;
    ack_valid[cpu] = 1'b1;
    ack_id[cpu*IW +: IW] = IW'(id);
    @(negedge clk);
    ack_valid = '0;
  endtask

  task automatic chk(input int cpu, input logic ev, input int eid, input string tag);
    logic [IW-1:0] aid;
    aid = irq_id[cpu*IW +: IW];
    n_chk++;
    if (irq_valid[cpu] !== ev || (ev && aid !== IW'(eid))) begin
      n_bad++;
      $display("FAIL %s cpu%0d: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               tag, cpu, irq_valid[cpu], aid, ev, eid);
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < NC; c++) chk(c, 1'b0, 0, "R1 reset idle");
  endtask

  task automatic t_latency();
    setup_src(5, 4'd3, 4'b0001, 1'b1);
    irq_in[5] = 1'b1;
    step();
    chk(0, 1'b0, 0, "R8 not yet after one edge");
    step();
    chk(0, 1'b1, 5, "R8 presented after second edge");
    chk(1, 1'b0, 0, "R5 untargeted cpu idle");
  endtask

  task automatic t_prio_tie();
    setup_src(9, 4'd1, 4'b0001, 1'b1);
    irq_in[9] = 1'b1;
    step(2);
    chk(0, 1'b1, 9, "R3 lower value wins");
    setup_src(2, 4'd1, 4'b0001, 1'b1);
    irq_in[2] = 1'b1;
    step(2);
    chk(0, 1'b1, 2, "R4 tie to lower id");
  endtask

  task automatic t_ack_rules();
    ack(0, 9);
    step();
    chk(0, 1'b1, 2, "R9 wrong id ignored");
    ack(1, 2);
    step();
    chk(0, 1'b1, 2, "R9 ack on idle cpu ignored");
    ack(0, 2);
    step();
    chk(0, 1'b1, 9, "R6 next after ack");
    ack(0, 9);
    step();
    chk(0, 1'b1, 5, "R3 last one left");
    ack(0, 5);
    step(3);
    chk(0, 1'b0, 0, "R10 held level does not re-pend");
    irq_in[5] = 1'b0;
    step();
    irq_in[5] = 1'b1;
    step(2);
    chk(0, 1'b1, 5, "R10 new edge re-pends");
    ack(0, 5);
    irq_in = '0;
    step();
    chk(0, 1'b0, 0, "R10 cleared");
  endtask

  task automatic t_mask();
    setup_src(12, 4'd0, 4'b0001, 1'b0);
    irq_in[12] = 1'b1;
    step(3);
    chk(0, 1'b0, 0, "R2 disabled not presented");
    wr(2'd0, 12, 4'd1);
    chk(0, 1'b0, 0, "R8 enable not yet visible");
    step();
    chk(0, 1'b1, 12, "R2 latched pending shown on enable");
    ack(0, 12);
    irq_in = '0;
    step();
    chk(0, 1'b0, 0, "R2 cleared");
  endtask

  task automatic t_shared();
    setup_src(20, 4'd2, 4'b0011, 1'b1);
    setup_src(21, 4'd1, 4'b0010, 1'b1);
    irq_in[20] = 1'b1;
    irq_in[21] = 1'b1;
    step(2);
    chk(0, 1'b1, 20, "R5 cpu0 sees 20");
    chk(1, 1'b1, 21, "R5 cpu1 sees 21");
    ack(1, 21);
    step();
    chk(1, 1'b1, 20, "R5 cpu1 falls to 20");
    ack(0, 20);
    step();
    chk(0, 1'b0, 0, "R6 shared clear cpu0");
    chk(1, 1'b0, 0, "R6 shared clear cpu1");
    irq_in = '0;
    step();
  endtask

  task automatic t_private();
    wr(2'd3, 0, 4'd1);
    irq_in[20] = 1'b1;
    step(2);
    chk(0, 1'b1, 20, "R7 cpu0 sees 20");
    chk(1, 1'b1, 20, "R7 cpu1 sees 20");
    ack(0, 20);
    step();
    chk(0, 1'b0, 0, "R7 acking cpu cleared");
    chk(1, 1'b1, 20, "R7 other cpu keeps it");
    ack(1, 20);
    step();
    chk(1, 1'b0, 0, "R7 second ack clears");
    irq_in = '0;
    step();
  endtask

  task automatic t_prio_change();
    setup_src(3, 4'd5, 4'b0100, 1'b1);
    setup_src(4, 4'd6, 4'b0100, 1'b1);
    irq_in[3] = 1'b1;
    irq_in[4] = 1'b1;
    step(2);
    chk(2, 1'b1, 3, "R3 cpu2 prio 5 over 6");
    chk(3, 1'b0, 0, "R5 cpu3 idle");
    wr(2'd1, 4, 4'd2);
    chk(2, 1'b1, 3, "R8 old winner one cycle");
    step();
    chk(2, 1'b1, 4, "R8 R3 new winner after rewrite");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    step(2);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_latency();
    t_prio_tie();
    t_ack_rules();
    t_mask();
    t_shared();
    t_private();
    t_prio_change();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule